// File: doc/BRIEF.md
# Transport Packet Output Formatter

This block sits at the end of a transport-stream receive path. It accepts decoded bytes one at a time, together with a start-of-packet mark, a mark that says the packet could not be fully corrected, and a level that reports whether the descrambler is locked. It presents them to a downstream consumer as packet data with its own output clock, a packet-start strobe, a data-valid level and a block-error flag.

A static control bit chooses between two output formats. In the first, a whole byte appears on the bus in each output clock period. In the second, one bit appears in each period, most significant bit first. The output clock polarity and the block-error polarity can each be inverted on their own. The block-error flag has two meanings, chosen by a mode bit. In one, it marks every byte of a bad packet. In the other, it stays asserted while good data flows and drops only on the first byte of a bad packet or while lock is missing.

Every output unit (a byte, or one bit in serial mode) lasts two system clock cycles. The output clock is low, before any inversion, in the first cycle and high in the second. New data is taken from the input at the end of the second cycle of a unit that closes a byte.

Top module: `tpo_formatter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, out_valid, out_start and out_data are all zero and in_ready is low.
- R2: out_clk toggles on every system clock cycle. With cfg_clk_inv low it is 0 in the first cycle of each unit and 1 in the second, and out_data changes only at the start of a unit. With cfg_clk_inv high the level is inverted.
- R3: With cfg_serial low, each accepted byte appears on out_data[7:0] for exactly one unit, and bytes appear in the order they were accepted.
- R4: With cfg_serial high, each accepted byte takes 8 consecutive units, bit 7 first and bit 0 last, carried on out_data[0] with out_data[7:1] held at zero.
- R5: out_start is high only in the first unit of a byte that was accepted with in_sop high. In serial mode this is the first bit only.
- R6: out_valid is high for every unit that carries accepted data and low for gap units. While out_valid is low, out_data keeps its previous value.
- R7: With cfg_err_mode low, the raw block-error level is high for every unit of a packet whose start byte carried in_uncorr high, and low for all other units and for gaps. in_uncorr is looked at only on bytes with in_sop high.
- R8: With cfg_err_mode high and lock present, the raw block-error level is high for all data and gaps, except for every unit of the start byte of a packet marked uncorrectable, where it is low.
- R9: With cfg_err_mode high, the raw block-error level is low whenever in_lock was low on the previous system clock cycle.
- R10: out_err equals the raw block-error level XOR cfg_err_inv.
- R11: in_ready is high only in the second cycle of a unit that ends a byte (every unit in parallel mode, the eighth bit in serial mode). A byte is taken at the clock edge where in_valid and in_ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | Input byte is the first of a packet |
| in_uncorr | input | 1 | Packet holds uncorrectable bytes (sampled with in_sop) |
| in_lock | input | 1 | Descrambler lock level |
| in_ready | output | 1 | Block takes a byte at the next edge |
| cfg_serial | input | 1 | 1 = bit-serial output, 0 = byte-parallel |
| cfg_clk_inv | input | 1 | Invert out_clk |
| cfg_err_inv | input | 1 | Invert out_err |
| cfg_err_mode | input | 1 | 1 = good-high error mode, 0 = whole-packet error mode |
| out_data | output | 8 | Output byte, or serial bit on bit 0 |
| out_clk | output | 1 | Output clock |
| out_start | output | 1 | Packet-start strobe |
| out_valid | output | 1 | Data-valid level |
| out_err | output | 1 | Block-error flag |

## Verification
The assertions assume that cfg_clk_inv, cfg_serial and cfg_err_mode are static during traffic, and that in_lock is a level that may change at any edge. The clock-toggle check is therefore guarded on a stable inversion bit and on the cycle after reset. The stimulus changes configuration only while reset is asserted. It drives inputs on falling edges and holds each byte until in_ready is seen, so every byte is taken exactly once. Lock is set before reset and is not changed during a packet, so the one-cycle lag of the lock path does not blur the expected error levels.

// File: rtl/tpo_pkg.sv
package tpo_pkg;

    localparam int BYTE_W = 8;

    // Byte held in the output stage with its packet markers.
    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              sop;
        logic              bad;
    } tpo_byte_t;

    typedef enum logic {
        ERR_WHOLE_PKT = 1'b0,
        ERR_GOOD_HIGH = 1'b1
    } tpo_err_mode_e;

    // Raw block-error level before polarity inversion.
    function automatic logic tpo_err_level(
        input tpo_err_mode_e mode,
        input logic          valid,
        input logic          pkt_bad,
        input logic          first_bad,
        input logic          lock_ok
    );
        logic lvl;
        if (mode == ERR_WHOLE_PKT)
            lvl = valid & pkt_bad;
        else
            lvl = lock_ok & ~first_bad;
        return lvl;
    endfunction

endpackage

// File: rtl/tpo_slot_timer.sv
module tpo_slot_timer #(
    parameter int DATA_W = 8,
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1,
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic serial,
    input  logic take,
    output logic phase,
    output logic at_boundary,
    output logic ready
);

    logic             phase_q;
    logic [CNT_W-1:0] bit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 1'b0;
            bit_q   <= LAST_BIT;
        end else begin
            phase_q <= ~phase_q;
            if (phase_q) begin
                if (!serial)
                    bit_q <= LAST_BIT;
                else if (bit_q == LAST_BIT)
                    bit_q <= take ? '0 : LAST_BIT;
                else
                    bit_q <= bit_q + 1'b1;
            end
        end
    end

    assign phase       = phase_q;
    assign at_boundary = ~serial | (bit_q == LAST_BIT);
    assign ready       = phase_q & at_boundary;

endmodule

// File: rtl/tpo_shifter.sv
module tpo_shifter
    import tpo_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              serial,
    input  logic              phase,
    input  logic              at_boundary,
    input  logic              take,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sop,
    output logic [DATA_W-1:0] bus,
    output logic              valid,
    output logic              start
);

    logic [DATA_W-1:0] sh_q;
    logic              valid_q;
    logic              start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            valid_q <= 1'b0;
            start_q <= 1'b0;
        end else if (phase) begin
            if (take) begin
                sh_q    <= in_data;
                valid_q <= 1'b1;
                start_q <= in_sop;
            end else if (!at_boundary) begin
                sh_q    <= {sh_q[DATA_W-2:0], 1'b0};
                start_q <= 1'b0;
            end else begin
                valid_q <= 1'b0;
                start_q <= 1'b0;
            end
        end
    end

    generate
        if (DATA_W > 1) begin : g_wide
            assign bus = serial ? {{(DATA_W-1){1'b0}}, sh_q[DATA_W-1]} : sh_q;
        end else begin : g_narrow
            assign bus = sh_q;
        end
    endgenerate

    assign valid = valid_q;
    assign start = start_q;

endmodule

// File: rtl/tpo_errflag.sv
module tpo_errflag
    import tpo_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic phase,
    input  logic at_boundary,
    input  logic take,
    input  logic in_sop,
    input  logic in_uncorr,
    input  logic in_lock,
    input  logic valid,
    input  logic mode,
    input  logic invert,
    output logic err
);

    logic pkt_bad_q;
    logic first_bad_q;
    logic lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pkt_bad_q   <= 1'b0;
            first_bad_q <= 1'b0;
            lock_q      <= 1'b0;
        end else begin
            lock_q <= in_lock;
            if (phase && take) begin
                if (in_sop)
                    pkt_bad_q <= in_uncorr;
                first_bad_q <= in_sop & in_uncorr;
            end else if (phase && at_boundary) begin
                first_bad_q <= 1'b0;
            end
        end
    end

    assign err = invert ^ tpo_err_level(tpo_err_mode_e'(mode), valid,
                                        pkt_bad_q, first_bad_q, lock_q);

endmodule

// File: rtl/tpo_formatter.sv
module tpo_formatter
    import tpo_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_uncorr,
    input  logic              in_lock,
    output logic              in_ready,
    input  logic              cfg_serial,
    input  logic              cfg_clk_inv,
    input  logic              cfg_err_inv,
    input  logic              cfg_err_mode,
    output logic [DATA_W-1:0] out_data,
    output logic              out_clk,
    output logic              out_start,
    output logic              out_valid,
    output logic              out_err
);

    logic phase;
    logic at_boundary;
    logic ready;
    logic take;
    logic valid;

    assign take = ready & in_valid;

    tpo_slot_timer #(.DATA_W(DATA_W)) timer_i (
        .clk         (clk),
        .rst         (rst),
        .serial      (cfg_serial),
        .take        (take),
        .phase       (phase),
        .at_boundary (at_boundary),
        .ready       (ready)
    );

    tpo_shifter #(.DATA_W(DATA_W)) shift_i (
        .clk         (clk),
        .rst         (rst),
        .serial      (cfg_serial),
        .phase       (phase),
        .at_boundary (at_boundary),
        .take        (take),
        .in_data     (in_data),
        .in_sop      (in_sop),
        .bus         (out_data),
        .valid       (valid),
        .start       (out_start)
    );

    tpo_errflag err_i (
        .clk         (clk),
        .rst         (rst),
        .phase       (phase),
        .at_boundary (at_boundary),
        .take        (take),
        .in_sop      (in_sop),
        .in_uncorr   (in_uncorr),
        .in_lock     (in_lock),
        .valid       (valid),
        .mode        (cfg_err_mode),
        .invert      (cfg_err_inv),
        .err         (out_err)
    );

    assign out_valid = valid;
    assign out_clk   = phase ^ cfg_clk_inv;
    assign in_ready  = ready;

endmodule

// File: rtl/tpo_formatter_chk.sv
module tpo_formatter_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_lock,
    input logic              cfg_clk_inv,
    input logic              cfg_err_inv,
    input logic              cfg_err_mode,
    input logic [DATA_W-1:0] out_data,
    input logic              out_clk,
    input logic              out_start,
    input logic              out_valid,
    input logic              out_err
);

    // R2
    clk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(cfg_clk_inv)) |-> (out_clk != $past(out_clk)));

    // R5
    start_in_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_start |-> out_valid);

    // R6
    gap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));

    // R7
    gap_err_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_err_mode && !out_valid) |-> (out_err == cfg_err_inv));

    // R9
    nolock_err_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_err_mode && !$past(rst) && !$past(in_lock)) |-> (out_err == cfg_err_inv));

endmodule

bind tpo_formatter tpo_formatter_chk #(.DATA_W(DATA_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .in_lock      (in_lock),
    .cfg_clk_inv  (cfg_clk_inv),
    .cfg_err_inv  (cfg_err_inv),
    .cfg_err_mode (cfg_err_mode),
    .out_data     (out_data),
    .out_clk      (out_clk),
    .out_start    (out_start),
    .out_valid    (out_valid),
    .out_err      (out_err)
);

// File: tb/tpo_formatter_tb.sv
module tpo_formatter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PKT_LEN    = 5;
    localparam int CAP_MAX    = 256;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_sop = 1'b0;
    logic       in_uncorr = 1'b0;
    logic       in_lock = 1'b1;
    logic       in_ready;
    logic       cfg_serial = 1'b0;
    logic       cfg_clk_inv = 1'b0;
    logic       cfg_err_inv = 1'b0;
    logic       cfg_err_mode = 1'b0;
    logic [7:0] out_data;
    logic       out_clk;
    logic       out_start;
    logic       out_valid;
    logic       out_err;

    int errors = 0;
    int checks = 0;

    logic [7:0] cap_d [CAP_MAX];
    logic       cap_s [CAP_MAX];
    logic       cap_e [CAP_MAX];
    int         n_cap = 0;
    logic [7:0] exp_d [CAP_MAX];
    logic       exp_s [CAP_MAX];
    logic       exp_e [CAP_MAX];
    int         n_exp = 0;
    logic       mon_en = 1'b0;
    logic [7:0] prev_d = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tpo_formatter dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_sop(in_sop), .in_uncorr(in_uncorr), .in_lock(in_lock),
        .in_ready(in_ready), .cfg_serial(cfg_serial), .cfg_clk_inv(cfg_clk_inv),
        .cfg_err_inv(cfg_err_inv), .cfg_err_mode(cfg_err_mode),
        .out_data(out_data), .out_clk(out_clk), .out_start(out_start),
        .out_valid(out_valid), .out_err(out_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Monitor: one sample per unit, in its second cycle.
    always @(negedge clk) begin
        if (!rst && mon_en && ((out_clk ^ cfg_clk_inv) == 1'b1)) begin
            if (out_valid) begin
                if (n_cap < CAP_MAX) begin
                    cap_d[n_cap] = out_data;
                    cap_s[n_cap] = out_start;
                    cap_e[n_cap] = out_err;
                end
                n_cap++;
            end else begin
                // R6 data held in gap
                chk(out_data == prev_d, "R6 gap hold", out_data, prev_d);
            end
            prev_d = out_data;
        end
    end

    function automatic logic [7:0] pkt_byte(input int seed, input int i);
        return (i == 0) ? 8'h47 : 8'(seed + i * 37);
    endfunction

    task automatic add_exp(input logic [7:0] b, input logic s, input logic e);
        exp_d[n_exp] = b; exp_s[n_exp] = s; exp_e[n_exp] = e; n_exp++;
    endtask

    task automatic expect_pkt(input int seed, input logic bad);
        for (int i = 0; i < PKT_LEN; i++) begin
            logic [7:0] b = pkt_byte(seed, i);
            logic raw;
            if (!cfg_err_mode) raw = bad;
            else raw = in_lock && !(i == 0 && bad);
            raw = raw ^ cfg_err_inv;
            if (!cfg_serial)
                add_exp(b, i == 0, raw);
            else
                for (int k = 7; k >= 0; k--)
                    add_exp({7'b0, b[k]}, (i == 0) && (k == 7), raw);
        end
    endtask

    task automatic push_byte(input logic [7:0] b, input logic sop, input logic unc);
        in_valid = 1'b1; in_data = b; in_sop = sop; in_uncorr = unc;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_uncorr = 1'b0;
    endtask

    task automatic send_pkt(input int seed, input logic bad);
        // non-start bytes of a good packet carry in_uncorr high: must be ignored (R7)
        for (int i = 0; i < PKT_LEN; i++)
            push_byte(pkt_byte(seed, i), i == 0, (i == 0) ? bad : !bad);
    endtask

    task automatic do_reset;
        mon_en = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset values
        chk(out_valid == 1'b0 && out_start == 1'b0, "R1 valid/start", {out_valid, out_start}, 0);
        chk(out_data == 8'h00, "R1 data", out_data, 0);
        chk(in_ready == 1'b0, "R11 ready in reset", in_ready, 0);
        chk(out_clk == cfg_clk_inv, "R2 clk level in reset", out_clk, cfg_clk_inv);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0 && out_data == 8'h00, "R1 first cycle", out_data, 0);
        chk(out_clk == !cfg_clk_inv, "R2 clk second half", out_clk, !cfg_clk_inv);
        chk(in_ready == 1'b1, "R11 ready at boundary", in_ready, 1);
        n_cap = 0; n_exp = 0; prev_d = 8'h00;
        mon_en = 1'b1;
    endtask

    task automatic run_case(input string tag, input logic ser, input logic cinv,
                            input logic einv, input logic mode, input logic lock,
                            input logic bad_a, input logic bad_b);
        rst = 1'b1;
        @(negedge clk);
        cfg_serial = ser; cfg_clk_inv = cinv; cfg_err_inv = einv;
        cfg_err_mode = mode; in_lock = lock;
        do_reset();
        expect_pkt(17, bad_a);
        expect_pkt(90, bad_b);
        send_pkt(17, bad_a);
        repeat (3) @(negedge clk);
        send_pkt(90, bad_b);
        repeat (60) @(negedge clk);
        chk(n_cap == n_exp, {tag, " R11 unit count"}, n_cap, n_exp);
        for (int i = 0; i < n_exp && i < n_cap; i++) begin
            chk(cap_d[i] == exp_d[i], {tag, ser ? " R4 serial data" : " R3 parallel data"},
                cap_d[i], exp_d[i]);
            chk(cap_s[i] == exp_s[i], {tag, " R5 start"}, cap_s[i], exp_s[i]);
            chk(cap_e[i] == exp_e[i],
                {tag, !mode ? " R7" : (lock ? " R8" : " R9"), einv ? " R10" : "", " err"},
                cap_e[i], exp_e[i]);
        end
    endtask

    task automatic t_par_whole;   run_case("par_whole",  0, 0, 0, 0, 1, 0, 1); endtask
    task automatic t_par_good;    run_case("par_good",   0, 1, 0, 1, 1, 0, 1); endtask
    task automatic t_par_nolock;  run_case("par_nolock", 0, 0, 1, 1, 0, 0, 1); endtask
    task automatic t_ser_whole;   run_case("ser_whole",  1, 0, 1, 0, 1, 1, 0); endtask
    task automatic t_ser_good;    run_case("ser_good",   1, 1, 0, 1, 1, 0, 1); endtask
    task automatic t_par_inv;     run_case("par_inv",    0, 1, 1, 0, 1, 1, 1); endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_par_whole();
        t_par_good();
        t_par_nolock();
        t_ser_whole();
        t_ser_good();
        t_par_inv();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule